// File: doc/BRIEF.md
# Security-Filtered Priority Field Accessor

This block holds one eight-bit priority value for each of 32 per-core private interrupts and gives a register port access to them through a small address window. The window answers single-byte accesses and aligned 32-bit accesses. Each request carries a secure flag. The block also takes the interrupt group vector, which is stored elsewhere, and a global flag that switches the security model off.

The view depends on the access. A secure access, or any access while security is switched off, sees each stored byte as it is. A non-secure access with security on cannot see a field whose interrupt is in group 0. It sees the other fields through a transform:
- A read returns the stored value shifted up one bit.
- A write stores the written value shifted down one bit, with the top bit forced to one.

A word access applies these rules to each of its four byte lanes on its own. After every error-free write the block sends a one-cycle update pulse to the logic that arbitrates priorities, even when every lane was filtered out.

Every request gets a registered response one cycle later. Fields are cleared by reset.

Top module: `prio_secview_acc`

## Requirements
- R1: After reset every priority field reads as 0x00, and `rsp_valid` and `upd_strobe` are low.
- R2: A secure access, or any access while `sec_disable` is 1, reads and writes the stored byte unchanged.
- R3: A non-secure read of a visible field, with security enabled, returns the stored value shifted left by one bit and truncated to 8 bits.
- R4: A non-secure write to a visible field, with security enabled, stores 0x80 OR (written byte shifted right by one).
- R5: A field is hidden when the access is non-secure, `sec_disable` is 0 and `grp_vec[irq]` is 0. A hidden field reads as 0x00 and ignores writes.
- R6: A word access at offset n covers interrupts n to n+3. Bits [8k+7:8k] map to interrupt n+k, and the rules R2 to R5 apply to each lane on its own.
- R7: A byte access at offsets 0x00 to 0x1F addresses the single field of that interrupt. The read result is in bits [7:0], and bits [31:8] are 0.
- R8: Any access at offset 0x20 or above returns `rsp_err`=1 and `rsp_rdata`=0, changes no field and raises no update pulse.
- R9: A word access whose offset is not a multiple of 4 is an error, with the same effects as in R8.
- R10: `upd_strobe` is high for exactly the response cycle of each error-free write, including writes whose lanes were all hidden. It is never high for a read.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_secure | input | 1 | 1 = secure access |
| req_addr | input | 8 | Byte offset within the window |
| req_wdata | input | 32 | Write data (byte access uses bits [7:0]) |
| grp_vec | input | 32 | Group bit per interrupt (1 = non-secure group) |
| sec_disable | input | 1 | 1 = security model switched off |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| upd_strobe | output | 1 | One-cycle pulse after an accepted write |

## Verification
Random accesses mix the secure flag, the security-disable flag, the group vector, byte and word sizes, and offsets that run just past the window. Every read is compared against a bench model of the stored bytes. This separates the unfiltered view, the shifted non-secure view and the zeroed hidden view, lane by lane within a single word. Directed cases add three checks:
- A non-secure word write with every lane hidden must still raise the update pulse but leave the contents unchanged when read back securely.
- A non-secure byte write must come back with its top bit forced.
- Misaligned word offsets and out-of-window offsets must return errors with no side effect.

// File: rtl/prio_acc_pkg.sv
package prio_acc_pkg;
    localparam int unsigned DEF_NUM_IRQ = 32;
    localparam int unsigned DEF_PRIO_W  = 8;
    localparam int unsigned DEF_LANES   = 4;
    localparam int unsigned DEF_ADDR_W  = 8;

    typedef struct packed {
        logic valid;
        logic err;
        logic upd;
    } rsp_flags_t;
endpackage

// File: rtl/prio_win_decode.sv
module prio_win_decode #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned LANES   = 4,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ),
    localparam int unsigned LB_W   = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_word,
    output logic              err,
    output logic [IDX_W-1:0]  base_idx,
    output logic [LANES-1:0]  lane_en
);
    logic in_range;
    logic aligned;

    always_comb begin
        in_range = (addr < ADDR_W'(NUM_IRQ));
        aligned  = !is_word || (addr[LB_W-1:0] == '0);
        err      = !(in_range && aligned);
        base_idx = addr[IDX_W-1:0];
        lane_en  = is_word ? '1 : LANES'(1);
    end
endmodule

// File: rtl/prio_lane_xform.sv
module prio_lane_xform #(
    parameter int unsigned PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] stored,
    input  logic [PRIO_W-1:0] wbyte,
    input  logic              grp_bit,
    input  logic              ns_restrict,
    output logic              hidden,
    output logic [PRIO_W-1:0] rd_view,
    output logic [PRIO_W-1:0] wr_val
);
    always_comb begin
        hidden = ns_restrict && !grp_bit;
        if (hidden)
            rd_view = '0;
        else if (ns_restrict)
            rd_view = {stored[PRIO_W-2:0], 1'b0};
        else
            rd_view = stored;
        wr_val = ns_restrict ? {1'b1, wbyte[PRIO_W-1:1]} : wbyte;
    end
endmodule

// File: rtl/prio_secview_acc.sv
module prio_secview_acc
    import prio_acc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = DEF_NUM_IRQ,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    parameter int unsigned LANES   = DEF_LANES,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned IDX_W  = $clog2(NUM_IRQ),
    localparam int unsigned DATA_W = LANES * PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NUM_IRQ-1:0] grp_vec,
    input  logic              sec_disable,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              upd_strobe
);
    typedef struct packed {
        logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
        rsp_flags_t                     flags;
        logic [DATA_W-1:0]              rdata;
    } state_t;

    state_t s_d, s_q;

    logic              dec_err;
    logic [IDX_W-1:0]  base_idx;
    logic [LANES-1:0]  lane_en;
    logic              ns_restrict;

    logic [IDX_W-1:0]  lane_idx  [LANES];
    logic [PRIO_W-1:0] lane_rd   [LANES];
    logic [PRIO_W-1:0] lane_wr   [LANES];
    logic              lane_hid  [LANES];

    assign ns_restrict = !req_secure && !sec_disable;

    prio_win_decode #(
        .ADDR_W (ADDR_W),
        .NUM_IRQ(NUM_IRQ),
        .LANES  (LANES)
    ) u_dec (
        .addr    (req_addr),
        .is_word (req_word),
        .err     (dec_err),
        .base_idx(base_idx),
        .lane_en (lane_en)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_idx[k] = base_idx + IDX_W'(k);
        prio_lane_xform #(.PRIO_W(PRIO_W)) u_xf (
            .stored     (s_q.prio[lane_idx[k]]),
            .wbyte      (req_wdata[k*PRIO_W +: PRIO_W]),
            .grp_bit    (grp_vec[lane_idx[k]]),
            .ns_restrict(ns_restrict),
            .hidden     (lane_hid[k]),
            .rd_view    (lane_rd[k]),
            .wr_val     (lane_wr[k])
        );
    end

    always_comb begin
        s_d             = s_q;
        s_d.flags.valid = req_valid;
        s_d.flags.err   = req_valid && dec_err;
        s_d.flags.upd   = 1'b0;
        s_d.rdata       = '0;
        if (req_valid && !dec_err) begin
            if (req_write) begin
                s_d.flags.upd = 1'b1;
                for (int k = 0; k < LANES; k++) begin
                    if (lane_en[k] && !lane_hid[k])
                        s_d.prio[lane_idx[k]] = lane_wr[k];
                end
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    if (lane_en[k])
                        s_d.rdata[k*PRIO_W +: PRIO_W] = lane_rd[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid  = s_q.flags.valid;
    assign rsp_err    = s_q.flags.err;
    assign rsp_rdata  = s_q.rdata;
    assign upd_strobe = s_q.flags.upd;

    // Checker support: remember a single-byte write's target and old value
    logic              a_hid_wr_q, a_vis_ns_wr_q;
    logic [IDX_W-1:0]  a_idx_q;
    logic [PRIO_W-1:0] a_old_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hid_wr_q    <= 1'b0;
            a_vis_ns_wr_q <= 1'b0;
            a_idx_q       <= '0;
            a_old_q       <= '0;
        end else begin
            a_hid_wr_q    <= req_valid && req_write && !req_word && !dec_err
                             && ns_restrict && !grp_vec[req_addr[IDX_W-1:0]];
            a_vis_ns_wr_q <= req_valid && req_write && !req_word && !dec_err
                             && ns_restrict && grp_vec[req_addr[IDX_W-1:0]];
            a_idx_q       <= req_addr[IDX_W-1:0];
            a_old_q       <= s_q.prio[req_addr[IDX_W-1:0]];
        end
    end

    a_r5_hidden_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        a_hid_wr_q |-> s_q.prio[a_idx_q] == a_old_q);

    a_r4_ns_write_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        a_vis_ns_wr_q |-> s_q.prio[a_idx_q][PRIO_W-1]);

    a_r8_err_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0) && !upd_strobe && rsp_valid);

    a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r10_strobe_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !upd_strobe);
endmodule

// File: tb/tb_prio_secview_acc.sv
module tb_prio_secview_acc;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_word, req_secure, sec_disable;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata, grp_vec;
    logic        rsp_valid, rsp_err, upd_strobe;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_prio [32];

    always #2.5 clk = ~clk;

    prio_secview_acc dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_secure(req_secure), .req_addr(req_addr),
        .req_wdata(req_wdata), .grp_vec(grp_vec), .sec_disable(sec_disable),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .upd_strobe(upd_strobe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(int idx, bit sec, bit dis, logic [31:0] g);
        bit ns = !sec && !dis;
        if (ns && !g[idx]) return 8'h00;
        if (ns) return {m_prio[idx][6:0], 1'b0};
        return m_prio[idx];
    endfunction

    function automatic logic [7:0] m_wval(logic [7:0] w, bit sec, bit dis);
        if (!sec && !dis) return {1'b1, w[7:1]};
        return w;
    endfunction

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic access(input bit wr, input bit wd, input bit sec, input bit dis,
                          input logic [7:0] addr, input logic [31:0] wdata,
                          input logic [31:0] g);
        bit          e_err;
        logic [31:0] e_rd;
        bit          e_upd;
        int          n;
        string       tag;
        n     = wd ? 4 : 1;
        e_err = (addr >= 8'h20) || (wd && addr[1:0] != 2'b00);
        e_rd  = '0;
        e_upd = 1'b0;
        if (!e_err) begin
            for (int k = 0; k < n; k++) begin
                int idx = int'(addr[4:0]) + k;
                bit hid = !sec && !dis && !g[idx];
                if (wr) begin
                    if (!hid) m_prio[idx] = m_wval(wdata[8*k +: 8], sec, dis);
                end else begin
                    e_rd[8*k +: 8] = m_read(idx, sec, dis, g);
                end
            end
            e_upd = wr;
        end
        req_valid = 1'b1; req_write = wr; req_word = wd; req_secure = sec;
        sec_disable = dis; req_addr = addr; req_wdata = wdata; grp_vec = g;
        @(negedge clk);
        if (addr >= 8'h20)  tag = "R8";
        else if (e_err)     tag = "R9";
        else if (wr)        tag = "R10 R4 R5";
        else if (wd)        tag = "R6 R2 R3 R5";
        else                tag = "R7 R2 R3 R5";
        chk(rsp_valid == 1'b1, "R11 rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_err == e_err, {tag, " err"}, 32'(rsp_err), 32'(e_err));
        chk(rsp_rdata == e_rd, {tag, " rdata"}, rsp_rdata, e_rd);
        chk(upd_strobe == e_upd, {tag, " upd_strobe"}, 32'(upd_strobe), 32'(e_upd));
        req_valid = 1'b0;
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 idle rsp_valid", 32'(rsp_valid), 32'd0);
        chk(upd_strobe == 1'b0, "R10 idle upd_strobe", 32'(upd_strobe), 32'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_1D42));
        for (int i = 0; i < 32; i++) m_prio[i] = 8'h00;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
        req_secure = 1'b0; sec_disable = 1'b0; req_addr = '0; req_wdata = '0;
        grp_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk(upd_strobe == 1'b0, "R1 upd_strobe", 32'(upd_strobe), 32'd0);
        for (int a = 0; a < 32; a += 4) access(0, 1, 1, 0, 8'(a), '0, '0);

        // R2/R6: secure word write and readback, lane order
        access(1, 1, 1, 0, 8'h04, 32'h4433_2211, 32'h0);
        access(0, 1, 1, 0, 8'h04, '0, 32'h0);
        // R3: non-secure shifted view of visible field 5
        access(0, 0, 0, 0, 8'h05, '0, 32'h0000_00F0);
        // R4: non-secure write forces top bit, read back securely
        access(1, 0, 0, 0, 8'h06, 32'h10, 32'h0000_00F0);
        access(0, 0, 1, 0, 8'h06, '0, 32'h0);
        // R5/R10: all lanes hidden, still strobes, contents kept
        access(1, 1, 0, 0, 8'h04, 32'hFFFF_FFFF, 32'h0);
        access(0, 1, 1, 0, 8'h04, '0, 32'h0);
        access(0, 1, 0, 0, 8'h04, '0, 32'h0000_0050);
        // R2: security disabled, non-secure access unfiltered
        access(1, 0, 0, 1, 8'h1F, 32'hA5, 32'h0);
        access(0, 0, 0, 1, 8'h1F, '0, 32'h0);
        // R7: byte read top field, upper bits zero
        access(0, 0, 1, 0, 8'h1F, '0, 32'h0);
        // R8/R9: errors with no side effect
        access(1, 0, 1, 0, 8'h20, 32'h77, 32'h0);
        access(0, 1, 1, 0, 8'h1C, '0, 32'h0);
        access(1, 1, 1, 0, 8'h05, 32'h1234_5678, 32'h0);
        access(0, 1, 1, 0, 8'h22, '0, 32'h0);
        access(0, 1, 1, 0, 8'h04, '0, 32'h0);
        idle_check();

        for (int i = 0; i < 3000; i++) begin
            bit          wr  = $urandom_range(0, 1) == 1;
            bit          wd  = $urandom_range(0, 1) == 1;
            bit          sec = $urandom_range(0, 2) == 0;
            bit          dis = $urandom_range(0, 4) == 0;
            logic [7:0]  ad  = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(32, 255))
                                                             : 8'($urandom_range(0, 31));
            logic [31:0] wdt = $urandom;
            logic [31:0] g   = $urandom;
            if (wd && $urandom_range(0, 7) != 0) ad[1:0] = 2'b00;
            access(wr, wd, sec, dis, ad, wdt, g);
            if ($urandom_range(0, 31) == 0) idle_check();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule